// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer behind a small synchronous register port. Software stores a reload value, picks a counting mode and a tick prescaler through a control register, and receives a level interrupt each time the count expires. The counter decrements once per prescaled tick. The prescaler takes a one-cycle tick-enable input and divides it by 1, 16 or 256.

At zero the counter does one of three things. In one-shot mode it stays at zero. In periodic mode it reloads from the stored value. In free-running mode it wraps to the all-ones value for the selected width, which is 16 or 32 bits. There are two ways to set the reload value. The immediate path also restarts the count. The background path leaves the running count alone, so the new period starts at the next wrap.

Reads are registered. The data for the word offset presented on one cycle appears on the read bus after the next clock edge. The interrupt output is registered and follows the raw expiry flag gated by the interrupt-enable bit.

Top module: `cdtimer`

## Requirements
- R1: After synchronous reset the control register reads 0x20 (interrupt enable set, counting stopped), the count and reload value are zero, the raw flag is clear and `irq_o` is low.
- R2: `bus_addr` is a word offset. Offset 0 is the load value, 1 the current count, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0) and 6 background load. Offsets 3 and 7 read zero. `bus_rdata` shows the value for the offset presented one cycle earlier, taken from the state before that edge.
- R3: Control bits 3:2 set the prescaler: 00 decrements on every tick, 01 on every 16th tick and 10 on every 256th tick. 11 behaves as 00. Ticks count only while control bit 7 (run) is set. A control write restarts the prescale count from zero, and no decrement happens in that cycle.
- R4: A write to offset 0 stores the reload value and loads the count from it in the same edge, masked to the active width. It takes priority over a decrement in that cycle.
- R5: A write to offset 6 stores the reload value without touching the count. Offsets 0 and 6 both read back the stored reload value.
- R6: On a decrement step with the count at zero, one-shot mode (control bit 0) keeps the count at zero. Otherwise periodic mode (bit 6) reloads the stored value, and free-running mode reloads 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R7: Writes to offset 1 change nothing.
- R8: A decrement step from one to zero sets the raw flag. Any write to offset 3 clears it, but an expiry in the same cycle wins.
- R9: `irq_o` and the masked status both equal the raw flag AND control bit 5. They update on the same edge as the flag or the control bit.
- R10: With control bit 1 clear the counter uses only its low 16 bits, and offset 1 reads zero in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick enable, one cycle per tick |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
A wrong count shows at the read port one cycle after offset 1 is addressed. A wrong reload or wrap choice shows on the first read after the counter passes zero. Prescaler faults stay hidden until the counter moves 16 or 256 ticks late or early, so the bench holds the tick input low while it reads registers. That way a single-tick slip shows up as a different count. The bench compares a reference model against the read bus and the interrupt pin on every clock, so a bad raw flag or a bad enable gate appears on `irq_o` within the same cycle.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

  localparam int OFS_W  = 3;
  localparam int CTRL_W = 8;

  localparam logic [OFS_W-1:0] OFS_LOAD  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_VALUE = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_ICLR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_RAW   = 3'd4;
  localparam logic [OFS_W-1:0] OFS_MSK   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_BGLD  = 3'd6;

  // Packed so that field positions match the control bit layout.
  typedef struct packed {
    logic       run;      // bit 7
    logic       rpt;      // bit 6
    logic       irq_en;   // bit 5
    logic       spare;    // bit 4
    logic [1:0] div;      // bits 3:2
    logic       wide;     // bit 1
    logic       single;   // bit 0
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // Last prescale count before a step, per divider code.
  function automatic logic [7:0] div_last(input logic [1:0] sel);
    case (sel)
      2'b01:   div_last = 8'd15;
      2'b10:   div_last = 8'd255;
      default: div_last = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/cdtimer_prescale.sv
module cdtimer_prescale
  import cdtimer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] div_i,
  output logic       step_o
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] last;
  logic             adv;

  generate
    if (PRE_W >= 8) begin : g_full
      assign last = PRE_W'(div_last(div_i));
    end else begin : g_trunc
      assign last = div_last(div_i)[PRE_W-1:0];
    end
  endgenerate

  assign adv    = run_i & tick_i & ~restart_i;
  assign step_o = adv & (pcnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pcnt_q <= '0;
    end else if (adv) begin
      pcnt_q <= step_o ? '0 : pcnt_q + PRE_W'(1);
    end
  end

  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (pcnt_q == '0));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !restart_i) |=> $stable(pcnt_q));

endmodule

// File: rtl/cdtimer_counter.sv
module cdtimer_counter #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              wide_i,
  input  logic              single_i,
  input  logic              rpt_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q, count_n;
  logic [DATA_W-1:0] mask, cur, wrap_val;
  logic              at_zero;

  assign mask     = wide_i ? '1 : NARROW_MASK;
  assign cur      = count_q & mask;
  assign at_zero  = (cur == '0);
  assign wrap_val = (rpt_i ? reload_i : mask) & mask;
  assign expire_o = step_i & ~load_we_i & (cur == ONE);
  assign count_o  = cur;

  always_comb begin
    count_n = count_q;
    if (load_we_i) begin
      count_n = load_val_i & mask;
    end else if (step_i) begin
      if (at_zero) begin
        if (!single_i) count_n = wrap_val;
      end else begin
        count_n = cur - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_n;
  end

  assert_single_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (single_i && at_zero && !load_we_i) |=> (count_q == $past(count_q)));

  assert_load_now_R4: assert property (@(posedge clk) disable iff (rst)
    load_we_i |=> (count_q == $past(load_val_i & mask)));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_we_i && !at_zero) |=> (count_q == $past(cur) - ONE));

endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
  import cdtimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              load_we_o,
  output logic              ctrl_we_o,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] reload_q, rdata_n;
  logic              raw_q, raw_n;
  logic              clr_we, bg_we;

  assign load_we_o = bus_wr && (bus_addr == OFS_LOAD);
  assign ctrl_we_o = bus_wr && (bus_addr == OFS_CTRL);
  assign clr_we    = bus_wr && (bus_addr == OFS_ICLR);
  assign bg_we     = bus_wr && (bus_addr == OFS_BGLD);

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  always_comb begin
    ctrl_n = ctrl_we_o ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    if (expire_i)    raw_n = 1'b1;
    else if (clr_we) raw_n = 1'b0;
    else             raw_n = raw_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_LOAD, OFS_BGLD: rdata_n = reload_q;
      OFS_VALUE:          rdata_n = count_i;
      OFS_CTRL:           rdata_n = DATA_W'(ctrl_q);
      OFS_RAW:            rdata_n = DATA_W'(raw_q);
      OFS_MSK:            rdata_n = DATA_W'(raw_q & ctrl_q.irq_en);
      default:            rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= ctrl_t'(CTRL_RESET);
      reload_q  <= '0;
      raw_q     <= 1'b0;
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_n;
      raw_q     <= raw_n;
      bus_rdata <= rdata_n;
      irq_o     <= raw_n & ctrl_n.irq_en;
      if (load_we_o || bg_we) reload_q <= bus_wdata;
    end
  end

  assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_q == ctrl_t'(CTRL_RESET)));

  assert_expire_sets_R8: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> raw_q);

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !expire_i) |=> !raw_q);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (raw_q & ctrl_q.irq_en));

endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, count;
  logic              load_we, ctrl_we, step, expire;

  cdtimer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_i   (count),
    .expire_i  (expire),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .load_we_o (load_we),
    .ctrl_we_o (ctrl_we),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  cdtimer_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .run_i     (ctrl.run),
    .restart_i (ctrl_we),
    .div_i     (ctrl.div),
    .step_o    (step)
  );

  cdtimer_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .load_we_i  (load_we),
    .load_val_i (bus_wdata),
    .reload_i   (reload),
    .wide_i     (ctrl.wide),
    .single_i   (ctrl.single),
    .rpt_i      (ctrl.rpt),
    .count_o    (count),
    .expire_o   (expire)
  );

endmodule

// File: tb/cdtimer_bench.sv
module cdtimer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;

  always #4 clk = ~clk;  // 125 MHz

  cdtimer u_cdtimer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Behavioural reference state.
  logic [31:0] m_reload, m_count, m_rdata;
  logic [7:0]  m_ctrl;
  logic        m_raw, m_irq;
  int          m_pcnt;
  logic [2:0]  m_raddr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R10";
      3'd2: return "R3";
      3'd4: return "R8";
      3'd5: return "R9";
      3'd6: return "R5";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] mask, cur;
    logic        cw, step, expire;
    int          lim;
    if (rst) begin
      m_ctrl = 8'h20; m_reload = 0; m_count = 0; m_raw = 0;
      m_irq = 0; m_pcnt = 0; m_rdata = 0; m_raddr = 0;
    end else begin
      case (bus_addr)
        3'd0, 3'd6: m_rdata = m_reload;
        3'd1: m_rdata = m_count & (m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
        3'd2: m_rdata = {24'd0, m_ctrl};
        3'd4: m_rdata = {31'd0, m_raw};
        3'd5: m_rdata = {31'd0, m_raw & m_ctrl[5]};
        default: m_rdata = 0;
      endcase
      m_raddr = bus_addr;
      mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      cur  = m_count & mask;
      cw   = bus_wr && bus_addr == 3'd2;
      lim  = (m_ctrl[3:2] == 2'b01) ? 15 : (m_ctrl[3:2] == 2'b10) ? 255 : 0;
      step = !cw && m_ctrl[7] && tick_i && (m_pcnt == lim);
      if (cw) m_pcnt = 0;
      else if (m_ctrl[7] && tick_i) m_pcnt = step ? 0 : m_pcnt + 1;
      expire = 0;
      if (bus_wr && bus_addr == 3'd0) m_count = bus_wdata & mask;
      else if (step) begin
        if (cur == 0) begin
          if (!m_ctrl[0]) m_count = (m_ctrl[6] ? m_reload : mask) & mask;
        end else begin
          expire = (cur == 1);
          m_count = cur - 1;
        end
      end
      if (expire) m_raw = 1;
      else if (bus_wr && bus_addr == 3'd3) m_raw = 0;
      if (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd6)) m_reload = bus_wdata;
      if (cw) m_ctrl = bus_wdata[7:0];
      m_irq = m_raw & m_ctrl[5];
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      chk(req_of(m_raddr), bus_rdata, m_rdata);
      chk("R9", {31'd0, irq_o}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    live = 1;
    chk("R1", bus_rdata, 32'd0);
    chk("R1", {31'd0, irq_o}, 32'd0);
    rd(3'd2, v); chk("R1", v, 32'h20);
    rd(3'd1, v); chk("R1", v, 32'd0);
    rd(3'd7, v); chk("R2", v, 32'd0);

    // one-shot stops at zero, raises flag
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA3);
    ticks(10);
    rd(3'd1, v); chk("R6", v, 32'd0);
    rd(3'd4, v); chk("R8", v, 32'd1);
    rd(3'd5, v); chk("R9", v, 32'd1);
    chk("R9", {31'd0, irq_o}, 32'd1);
    wr(3'd3, 32'd0);
    rd(3'd4, v); chk("R8", v, 32'd0);
    chk("R9", {31'd0, irq_o}, 32'd0);

    // free-running 16-bit wraps to 0xFFFF
    wr(3'd2, 32'h00); wr(3'd0, 32'd1); wr(3'd2, 32'hA0);
    ticks(2);
    rd(3'd1, v); chk("R6", v, 32'h0000_FFFF);
    // free-running 32-bit wraps to all ones
    wr(3'd2, 32'h00); wr(3'd0, 32'd1); wr(3'd2, 32'hA2);
    ticks(2);
    rd(3'd1, v); chk("R6", v, 32'hFFFF_FFFF);

    // background load keeps count; periodic reload uses it
    wr(3'd2, 32'h00); wr(3'd0, 32'd1); wr(3'd6, 32'd9);
    rd(3'd1, v); chk("R5", v, 32'd1);
    rd(3'd0, v); chk("R5", v, 32'd9);
    rd(3'd6, v); chk("R5", v, 32'd9);
    wr(3'd2, 32'hE2);
    ticks(2);
    rd(3'd1, v); chk("R6", v, 32'd9);
    wr(3'd1, 32'd55);
    rd(3'd1, v); chk("R7", v, 32'd9);

    // 16-bit load masking
    wr(3'd2, 32'h00); wr(3'd0, 32'h0001_2345);
    rd(3'd1, v); chk("R10", v, 32'h0000_2345);
    rd(3'd0, v); chk("R4", v, 32'h0001_2345);

    // divide by 16 and 256
    wr(3'd0, 32'd50); wr(3'd2, 32'hA6);
    ticks(15); rd(3'd1, v); chk("R3", v, 32'd50);
    ticks(1);  rd(3'd1, v); chk("R3", v, 32'd49);
    wr(3'd0, 32'd50); wr(3'd2, 32'hAA);
    ticks(255); rd(3'd1, v); chk("R3", v, 32'd50);
    ticks(1);   rd(3'd1, v); chk("R3", v, 32'd49);

    // interrupt masked off
    wr(3'd3, 32'd0);
    wr(3'd2, 32'h00); wr(3'd0, 32'd1); wr(3'd2, 32'h82);
    ticks(1);
    rd(3'd4, v); chk("R8", v, 32'd1);
    rd(3'd5, v); chk("R9", v, 32'd0);
    chk("R9", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'h22);
    chk("R9", {31'd0, irq_o}, 32'd1);
    rd(3'd5, v); chk("R9", v, 32'd1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      tick_i = ($urandom % 4) != 0;
      bus_addr = 3'($urandom % 8);
      if (r < 2) begin
        bus_wr = 1;
        case (bus_addr)
          3'd2: bus_wdata = {24'd0, 1'b1, 7'($urandom)};
          3'd0, 3'd6: bus_wdata = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 40);
          default: bus_wdata = $urandom;
        endcase
      end else bus_wr = 0;
      @(negedge clk);
    end
    bus_wr = 0; tick_i = 0;
    @(negedge clk);
    finish_run();
  end

endmodule